// File: doc/BRIEF.md
# Register-Group Bitmap Bank

This block keeps a bank of 32 control registers. Each holds a 32-bit bitmap in which bit k set means "architectural integer register xk belongs to this group". An operand field of an instruction picks one entry, and the set bits of that entry name the registers the operation is spread across. The number of set bits in the destination operand's entry is the vector length, meaning the number of element operations issued side by side.

Writes follow write-any/read-legal rules. Software may offer any 32-bit value through the single write port. The bank keeps only a legal value, and a later read shows what was actually granted. A group may never be empty, so an all-zero write is refused: the entry keeps its old value and a sticky flag records the refusal. Entry 0 is read-only and always names only x0. Two combinational read ports, each with its own index, return a stored bitmap and the population count of an entry.

Top module: `grp_bitmap_bank`

## Requirements
- R1: After reset, entry n reads as 1<<n on the bitmap port, and every entry reads a count of 1 on the count port.
- R2: A write with wr_en_i high, wr_idx_i in 1..31 and nonzero wr_data_i stores wr_data_i exactly. The read ports show the new value from the cycle after the write edge, and show the old value in the cycle in which wr_en_i is high.
- R3: Entry 0 always reads 32'h0000_0001 (only x0) with a count of 1. Writes to index 0 leave it unchanged.
- R4: A write with wr_en_i high and wr_data_i equal to zero leaves the addressed entry and all other entries unchanged.
- R5: zero_rej_o is 0 after reset. It goes to 1 in the cycle after any write with wr_en_i high and all-zero data (at any index), and stays 1 until reset. Nonzero writes do not set it.
- R6: cnt_o equals the number of set bits of the entry selected by cnt_idx_i, in the range 1 to 32, and changes combinationally with cnt_idx_i.
- R7: The bitmap port (rd_idx_i) and the count port (cnt_idx_i) address entries independently of each other.
- R8: No entry ever holds an all-zero bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 5 | Entry to write |
| wr_data_i | input | 32 | Offered bitmap |
| rd_idx_i | input | 5 | Entry for the bitmap read port |
| rd_map_o | output | 32 | Legal bitmap of the entry at rd_idx_i |
| cnt_idx_i | input | 5 | Entry for the count read port |
| cnt_o | output | 6 | Set-bit count of the entry at cnt_idx_i |
| zero_rej_o | output | 1 | Sticky: an all-zero write was refused |

## Verification
The bench sweeps all 32 entries after reset and after a full round of writes, on both read ports. It compares each read against a bench model with an arithmetic bit count, so a wrong reset pattern, a lost bit or a miscounted popcount shows up at once. It also hits the awkward cases. An all-zero write must neither clear an entry nor skip the flag. A write to entry 0 must be dropped rather than stored. Reading during the write cycle must still return the old value, so a read path that bypasses the register gets caught. The all-ones bitmap, with a count of 32, checks that the count output has enough width.

// File: rtl/grp_bitmap_pkg.sv
package grp_bitmap_pkg;
  typedef enum logic [1:0] {
    WR_NONE      = 2'd0,
    WR_TAKE      = 2'd1,
    WR_DROP_RO   = 2'd2,
    WR_DROP_ZERO = 2'd3
  } wr_verdict_e;
endpackage

// File: rtl/gbb_legalize.sv
module gbb_legalize
  import grp_bitmap_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [NUM_REGS-1:0] wr_data_i,
  output wr_verdict_e         verdict_o
);
  always_comb begin
    if (!wr_en_i)                  verdict_o = WR_NONE;
    else if (wr_data_i == '0)      verdict_o = WR_DROP_ZERO;
    else if (wr_idx_i == '0)       verdict_o = WR_DROP_RO;
    else                           verdict_o = WR_TAKE;
  end
endmodule

// File: rtl/gbb_entry.sv
module gbb_entry #(
  parameter int NUM_REGS = 32,
  parameter logic [NUM_REGS-1:0] RST_VAL = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic [NUM_REGS-1:0] d_i,
  output logic [NUM_REGS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (ld_i) q_o <= d_i;
  end

  assert_never_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o != '0);
endmodule

// File: rtl/gbb_popcount.sv
module gbb_popcount #(
  parameter int NUM_REGS = 32,
  localparam int CNT_W = $clog2(NUM_REGS + 1)
) (
  input  logic [NUM_REGS-1:0] map_i,
  output logic [CNT_W-1:0]    cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < NUM_REGS; k++) cnt_o = cnt_o + CNT_W'(map_i[k]);
  end
endmodule

// File: rtl/grp_bitmap_bank.sv
module grp_bitmap_bank
  import grp_bitmap_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(NUM_REGS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [NUM_REGS-1:0] wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [NUM_REGS-1:0] rd_map_o,
  input  logic [IDX_W-1:0]    cnt_idx_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                zero_rej_o
);
  wr_verdict_e         verdict;
  logic [NUM_REGS-1:0] map_q [NUM_REGS];

  gbb_legalize #(.NUM_REGS(NUM_REGS)) legal_i (
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_data_i(wr_data_i),
    .verdict_o(verdict)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    if (g == 0) begin : g_fixed
      // entry 0 is hardwired to {x0}
      assign map_q[g] = NUM_REGS'(1);
    end else begin : g_reg
      gbb_entry #(
        .NUM_REGS(NUM_REGS),
        .RST_VAL (NUM_REGS'(1) << g)
      ) ent_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ld_i  (verdict == WR_TAKE && wr_idx_i == IDX_W'(g)),
        .d_i   (wr_data_i),
        .q_o   (map_q[g])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       zero_rej_o <= 1'b0;
    else if (verdict == WR_DROP_ZERO)  zero_rej_o <= 1'b1;
  end

  assign rd_map_o = map_q[rd_idx_i];

  gbb_popcount #(.NUM_REGS(NUM_REGS)) pop_i (
    .map_i(map_q[cnt_idx_i]),
    .cnt_o(cnt_o)
  );

  assert_entry0_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == '0 |-> rd_map_o == NUM_REGS'(1));
  assert_write_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != '0 && wr_data_i != '0) |=> map_q[$past(wr_idx_i)] == $past(wr_data_i));
  assert_zero_write_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == '0) |=> map_q[$past(wr_idx_i)] == $past(map_q[wr_idx_i]));
  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_rej_o |=> zero_rej_o);
  assert_flag_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == '0) |=> zero_rej_o);
  assert_count_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o != '0 && cnt_o <= CNT_W'(NUM_REGS));
endmodule

// File: tb/grp_bitmap_bank_tb_top.sv
module grp_bitmap_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_map;
  logic [4:0]  cnt_idx = '0;
  logic [5:0]  cnt;
  logic        zero_rej;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  grp_bitmap_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_map_o(rd_map),
    .cnt_idx_i(cnt_idx), .cnt_o(cnt), .zero_rej_o(zero_rej)
  );

  function automatic int ones(logic [31:0] v);
    int c = 0;
    for (int k = 0; k < 32; k++) if (v[k]) c++;
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read entry e on both ports, ports crossed for R7
  task automatic check_entry(string req, int e);
    rd_idx = 5'(e);
    cnt_idx = 5'(31 - e);
    #1;
    chk({req, " map"}, rd_map, model[e]);
    chk({req, " R7 cnt"}, 32'(cnt), 32'(ones(model[31 - e])));
  endtask

  task automatic write(int e, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(e); wr_data = d;
    rd_idx = 5'(e);
    #1 chk("R2 old value during write", rd_map, model[e]);
    @(negedge clk);
    wr_en = 1'b0;
    if (d != 0 && e != 0) model[e] = d;
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int e = 0; e < 32; e++) model[e] = 32'd1 << e;
    #10 rst_n = 1'b1;
    @(negedge clk);
    chk("R5 flag after reset", 32'(zero_rej), 0);
    for (int e = 0; e < 32; e++) check_entry("R1 reset", e);

    // R2: fill entries 1..31 with arithmetic patterns
    for (int e = 1; e < 32; e++) write(e, (32'(e) * 32'h9E37_79B9) | 32'(e));
    for (int e = 0; e < 32; e++) check_entry("R2 written", e);
    chk("R5 no flag on nonzero writes", 32'(zero_rej), 0);

    // R6: all-ones and single-bit extremes
    write(7, 32'hFFFF_FFFF);
    cnt_idx = 5'd7; #1 chk("R6 full count", 32'(cnt), 32);
    write(9, 32'h8000_0000);
    cnt_idx = 5'd9; #1 chk("R6 top bit count", 32'(cnt), 1);

    // R3: entry 0 read-only
    write(0, 32'hDEAD_BEEF);
    rd_idx = 5'd0; cnt_idx = 5'd0;
    #1 chk("R3 entry0 map", rd_map, 32'h1);
    chk("R3 entry0 cnt", 32'(cnt), 1);
    chk("R5 no flag on entry0 write", 32'(zero_rej), 0);

    // R4/R5: zero write refused, flag sticks
    write(5, 32'h0);
    for (int e = 0; e < 32; e++) check_entry("R4 zero write kept", e);
    chk("R5 flag set", 32'(zero_rej), 1);
    write(12, 32'h0000_0F00);
    check_entry("R2 after reject", 12);
    repeat (3) @(negedge clk);
    chk("R5 flag sticky", 32'(zero_rej), 1);

    // R8: every entry nonzero
    for (int e = 0; e < 32; e++) begin
      rd_idx = 5'(e); #1 chk("R8 nonempty", 32'(rd_map != 0), 1);
    end

    // reset clears flag and reloads defaults
    rst_n = 1'b0; #5 rst_n = 1'b1;
    for (int e = 0; e < 32; e++) model[e] = 32'd1 << e;
    @(negedge clk);
    chk("R5 flag cleared by reset", 32'(zero_rej), 0);
    for (int e = 0; e < 32; e++) check_entry("R1 re-reset", e);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule